// File: doc/BRIEF.md
# Constant-Ones Hybrid Prefix Adder

This block adds a fully variable N-bit operand to a second operand whose upper N-L bits are fixed at one and whose lower L bits are supplied at a port, plus a carry-in. That operand shape turns up wherever a subtraction or a modular correction adds a value with a long run of ones at the top, for example in reverse converters for residue number arithmetic.

The adder is split at bit L. The variable low field is summed by a Brent-Kung parallel prefix network: bitwise generate and propagate, a log-depth up-sweep and down-sweep of group cells, then a XOR stage for the sum. The carry-in is merged at position zero as a generate with zero propagate. The carry leaving bit L-1 feeds a ripple chain over the upper field. There the addend bit is always one, so each stage reduces to an inverted XOR for the sum and an OR for the carry. The block is purely combinational. L must be a power of two and N must be greater than L.

Top module: `hcpa_adder`

## Requirements
- R1: sum_o equals (a_i + C + cin_i) mod 2^N, where C is b_lo_i in bits L-1..0 with every bit from L to N-1 set to one.
- R2: sum_o[L-1:0] equals (a_i[L-1:0] + b_lo_i + cin_i) mod 2^L, whatever the value of a_i[N-1:L].
- R3: The carry entering bit L is one exactly when a_i[L-1:0] + b_lo_i + cin_i is at least 2^L, and sum_o[N-1:L] equals (a_i[N-1:L] + 2^(N-L) - 1 + that carry) mod 2^(N-L).
- R4: cout_o is one exactly when a_i + C + cin_i is at least 2^N.
- R5: cout_o is one whenever a_i[N-1:L] is non-zero. Otherwise it equals the carry entering bit L. When that field is zero and no carry enters bit L, sum_o[N-1:L] is all ones and cout_o is zero.
- R6: With a_i and b_lo_i held, raising cin_i from 0 to 1 increases the (N+1)-bit value {cout_o, sum_o} by exactly one.
- R7: The outputs depend only on the present inputs. Returning to an earlier input vector, after other vectors have been applied, gives the same outputs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Fully variable addend |
| b_lo_i | input | L | Variable low field of the second addend; its upper field is implied all ones |
| cin_i | input | 1 | Carry-in at bit 0 |
| sum_o | output | N | Sum modulo 2^N |
| cout_o | output | 1 | Carry leaving bit N-1 |

## Verification
The bench sweeps every combination of a_i, b_lo_i and cin_i for a 10-bit adder with a 4-bit variable field. This covers every hand-off across the field boundary.

- A carry that is lost or duplicated at bit L would leave the upper field one too low or one too high exactly when the low field overflows. The carry-in corner, a low field of all ones with cin_i set, targets this case.
- A ripple stage that uses a plain XOR instead of the inverted one would flip upper sum bits whenever a_i has a zero high field.
- A wrong prefix pairing in the down-sweep would corrupt only middle bits of the low field for particular carry patterns, and the exhaustive sweep reaches those patterns.
- Cout is also checked against both of its sources: a non-zero upper field of a_i, and the carry into bit L.

// File: rtl/hcpa_pkg.sv
package hcpa_pkg;

    // Group generate of a hi/lo pair: used by both black and gray cells.
    function automatic logic pfx_gen(input logic g_hi, input logic p_hi, input logic g_lo);
        return g_hi | (p_hi & g_lo);
    endfunction

    // Group propagate of a hi/lo pair: black cells only.
    function automatic logic pfx_prop(input logic p_hi, input logic p_lo);
        return p_hi & p_lo;
    endfunction

    // Upper-field cell with the second addend fixed at one.
    function automatic logic ones_sum(input logic a, input logic c);
        return ~(a ^ c);
    endfunction

    function automatic logic ones_carry(input logic a, input logic c);
        return a | c;
    endfunction

endpackage

// File: rtl/hcpa_pre.sv
module hcpa_pre #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen_o[i]  = a_i[i] & b_i[i];
        assign prop_o[i] = a_i[i] ^ b_i[i];
    end
endmodule

// File: rtl/hcpa_bk_tree.sv
module hcpa_bk_tree
    import hcpa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o   // carry_o[i] enters bit i; carry_o[W] leaves the field
);
    localparam int LOG2W = $clog2(W);

    always_comb begin : bk_net
        logic [W-1:0] g_d;
        logic [W-1:0] p_d;
        g_d = gen_i;
        p_d = prop_i;
        // carry-in as position-zero generate with zero propagate, merged by a gray cell
        g_d[0] = pfx_gen(gen_i[0], prop_i[0], cin_i);
        p_d[0] = 1'b0;
        // up-sweep: node i absorbs the span of node i - 2^k
        for (int k = 0; k < LOG2W; k++) begin
            for (int i = 0; i < W; i++) begin
                if (((i + 1) % (2 << k)) == 0) begin
                    if (i == (2 << k) - 1) begin
                        g_d[i] = pfx_gen(g_d[i], p_d[i], g_d[i - (1 << k)]);
                    end else begin
                        g_d[i] = pfx_gen(g_d[i], p_d[i], g_d[i - (1 << k)]);
                        p_d[i] = pfx_prop(p_d[i], p_d[i - (1 << k)]);
                    end
                end
            end
        end
        // down-sweep: gray cells finish the remaining prefixes
        for (int k = LOG2W - 2; k >= 0; k--) begin
            for (int i = 0; i < W; i++) begin
                if ((((i + 1) % (2 << k)) == (1 << k)) && (i > (1 << k))) begin
                    g_d[i] = pfx_gen(g_d[i], p_d[i], g_d[i - (1 << k)]);
                end
            end
        end
        carry_o = {g_d, cin_i};
    end
endmodule

// File: rtl/hcpa_ones_ripple.sv
module hcpa_ones_ripple
    import hcpa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] chain_d;
    assign chain_d[0] = cin_i;

    for (genvar j = 0; j < W; j++) begin : g_cell
        assign sum_o[j]       = ones_sum(a_i[j], chain_d[j]);
        assign chain_d[j + 1] = ones_carry(a_i[j], chain_d[j]);
    end

    assign cout_o = chain_d[W];
endmodule

// File: rtl/hcpa_adder.sv
module hcpa_adder #(
    parameter int N = 16,
    parameter int L = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [L-1:0] b_lo_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    localparam int H = N - L;

    logic [L-1:0] gen_d;
    logic [L-1:0] prop_d;
    logic [L:0]   carry_d;
    logic         carry_mid;

    hcpa_pre #(.W(L)) u_pre (
        .a_i    (a_i[L-1:0]),
        .b_i    (b_lo_i),
        .gen_o  (gen_d),
        .prop_o (prop_d)
    );

    hcpa_bk_tree #(.W(L)) u_tree (
        .gen_i   (gen_d),
        .prop_i  (prop_d),
        .cin_i   (cin_i),
        .carry_o (carry_d)
    );

    assign sum_o[L-1:0] = prop_d ^ carry_d[L-1:0];
    assign carry_mid    = carry_d[L];

    hcpa_ones_ripple #(.W(H)) u_upper (
        .a_i    (a_i[N-1:L]),
        .cin_i  (carry_mid),
        .sum_o  (sum_o[N-1:L]),
        .cout_o (cout_o)
    );
endmodule

// File: rtl/hcpa_adder_chk.sv
module hcpa_adder_chk #(
    parameter int N = 16,
    parameter int L = 8
) (
    input logic [N-1:0] a_i,
    input logic [L-1:0] b_lo_i,
    input logic         cin_i,
    input logic [N-1:0] sum_o,
    input logic         cout_o,
    input logic         carry_mid
);
    localparam int H = N - L;

    logic [N:0] full_ref;
    logic [L:0] low_ref;
    logic [H:0] hi_ref;

    always_comb begin
        full_ref = {1'b0, a_i} + {1'b0, {H{1'b1}}, b_lo_i} + {{N{1'b0}}, cin_i};
        low_ref  = {1'b0, a_i[L-1:0]} + {1'b0, b_lo_i} + {{L{1'b0}}, cin_i};
        hi_ref   = {1'b0, a_i[N-1:L]} + {1'b0, {H{1'b1}}} + {{H{1'b0}}, carry_mid};

        assert_full_sum_R1: assert (sum_o == full_ref[N-1:0])
            else $error("R1 sum mismatch");
        assert_low_field_R2: assert (sum_o[L-1:0] == low_ref[L-1:0])
            else $error("R2 low field mismatch");
        assert_mid_carry_R3: assert (carry_mid == low_ref[L])
            else $error("R3 boundary carry mismatch");
        assert_high_field_R3: assert (sum_o[N-1:L] == hi_ref[H-1:0])
            else $error("R3 upper field mismatch");
        assert_cout_R4: assert (cout_o == full_ref[N])
            else $error("R4 carry-out mismatch");
        assert_cout_source_R5: assert (cout_o == ((|a_i[N-1:L]) | carry_mid) && cout_o == hi_ref[H])
            else $error("R5 carry-out source mismatch");
    end
endmodule

bind hcpa_adder hcpa_adder_chk #(.N(N), .L(L)) u_chk (
    .a_i       (a_i),
    .b_lo_i    (b_lo_i),
    .cin_i     (cin_i),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .carry_mid (carry_mid)
);

// File: tb/test_hcpa_adder.sv
module test_hcpa_adder;
    localparam int N = 10;
    localparam int L = 4;
    localparam int H = N - L;
    localparam int ONES_HI = ((1 << N) - 1) ^ ((1 << L) - 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [N-1:0] a;
    logic [L-1:0] b;
    logic         cin;
    logic [N-1:0] sum;
    logic         cout;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    hcpa_adder #(.N(N), .L(L)) i_hcpa_adder (
        .a_i    (a),
        .b_lo_i (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    task automatic apply(input int av, input int bv, input int cv);
        @(posedge clk);
        a   = av[N-1:0];
        b   = bv[L-1:0];
        cin = cv[0];
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d cin=%0d)",
                     req, act, exp, a, b, cin);
        end
    endtask

    function automatic int total(input int av, input int bv, input int cv);
        return av + (ONES_HI | bv) + cv;
    endfunction

    function automatic int outval();
        return (int'(cout) << N) | int'(sum);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;

        // all-zero inputs: upper field all ones, no carry-out (R5)
        apply(0, 0, 0);
        check("R5 zero inputs sum", int'(sum), ONES_HI);
        check("R5 zero inputs cout", int'(cout), 0);

        // low field all ones: carry crosses boundary only with cin (R3, R4)
        apply(15, 0, 0);
        check("R3 no boundary carry", int'(sum), 1023);
        check("R4 no carry-out", int'(cout), 0);
        apply(15, 0, 1);
        check("R3 boundary carry wraps", int'(sum), 0);
        check("R4 carry-out from boundary", int'(cout), 1);

        // every input at its maximum (R1)
        apply(1023, 15, 1);
        check("R1 max operands", outval(), 2047);

        // exhaustive sweep
        for (int av = 0; av < (1 << N); av++) begin
            for (int bv = 0; bv < (1 << L); bv++) begin
                for (int cv = 0; cv < 2; cv++) begin
                    int t;
                    int lo;
                    int cm;
                    t  = total(av, bv, cv);
                    lo = (av % (1 << L)) + bv + cv;
                    cm = lo >> L;
                    apply(av, bv, cv);
                    check("R1 full sum", int'(sum), t % (1 << N));
                    check("R2 low field", int'(sum) % (1 << L), lo % (1 << L));
                    check("R3 upper field", int'(sum) >> L,
                          ((av >> L) + (1 << H) - 1 + cm) % (1 << H));
                    check("R4 carry-out", int'(cout), t >> N);
                    check("R5 carry-out source", int'(cout), ((av >> L) != 0 || cm != 0) ? 1 : 0);
                end
            end
        end

        // low field unaffected by upper bits of a (R2)
        for (int hi = 0; hi < (1 << H); hi += 9) begin
            apply((hi << L) | 9, 6, 1);
            check("R2 upper a ignored", int'(sum) % (1 << L), 0);
        end

        // cin adds exactly one (R6)
        for (int k = 0; k < 40; k++) begin
            int av;
            int bv;
            int base;
            av = (k * 97 + 13) % (1 << N);
            bv = (k * 5 + 3) % (1 << L);
            apply(av, bv, 0);
            base = outval();
            apply(av, bv, 1);
            check("R6 cin increment", outval(), (base + 1) % (1 << (N + 1)));
        end

        // same inputs after other vectors give the same outputs (R7)
        for (int k = 0; k < 20; k++) begin
            int first;
            int av;
            av = (k * 211 + 7) % (1 << N);
            apply(av, k % (1 << L), k % 2);
            first = outval();
            apply(1023 - av, 15 - (k % (1 << L)), 1 - (k % 2));
            apply(av, k % (1 << L), k % 2);
            check("R7 no state", outval(), first);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule